// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sequences one bus cycle at a time on a shared address/data bus for a 16-bit processor. A transfer request carries an address, a read/write flag, a high-byte enable and write data. Once the controller accepts the request, it steps through the clock states T1, T2, T3, optional wait states, and T4. In T1 it drives the address and pulses the address latch enable strobe. T2 turns the bus around. Data then moves during T3, any wait states, and T4.

The shared pins appear as three signals: an output value, an output enable and an input value. External pad logic joins them into a tristate bus. A data enable and a transmit/receive direction output control an external transceiver. Read data comes back with a one-cycle completion pulse in T4. A request presented during T4 starts its T1 on the next clock. With no request pending, the controller rests in idle states.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, bus_state is 0 (idle), req_ready is 1, and ale, den, ad_oe, dt_r and rsp_valid are 0.
- R2: A clock edge with req_valid and req_ready both high starts T1 (bus_state 1) on the next cycle. In T1, ad_out equals the request address, ad_oe=1, ale=1, den=0, bhe_n equals the inverse of req_hi, and dt_r equals req_write.
- R3: T1 is always followed by T2 (bus_state 2), and T2 by T3 (bus_state 3). ale is high only in T1.
- R4: ready_in is sampled at the end of T3 and of each wait state (bus_state 4). If it is high the next state is T4 (bus_state 5), otherwise another wait state. N low samples give exactly N wait states.
- R5: For a write, dt_r=1 from T1 through T4. From T2 through T4, ad_oe=1 and ad_out carries the write data, zero-extended.
- R6: For a read, dt_r=0 throughout. From T2 through T4, ad_oe=0 and ad_out=0. rsp_rdata is the ad_in value present at the final T3/wait edge where ready_in is high. ad_in at any other time has no effect.
- R7: den is 1 from T2 through T4 for both reads and writes, and 0 in T1 and in idle.
- R8: rsp_valid is high for exactly the T4 cycle of each bus cycle.
- R9: req_ready is high only in idle and T4. From T4, a pending request moves the controller straight to T1; otherwise it returns to idle.
- R10: With no request, the controller stays idle with ale=0, den=0, ad_oe=0, dt_r=0, bhe_n=1 and ad_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_hi | input | 1 | High byte lane enabled |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request is taken on this edge if req_valid is high |
| ad_out | output | AW | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | DW | Shared bus input value |
| ale | output | 1 | Address latch enable strobe |
| bhe_n | output | 1 | High byte enable, active low, valid in T1 |
| den | output | 1 | Data enable for the transceiver |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| ready_in | input | 1 | Device ready |
| rsp_valid | output | 1 | Cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| bus_state | output | 3 | Current clock state: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |

## Verification
The state register follows the edge that accepts a request, so the T1 outputs are due one cycle after acceptance. Each later state is due one cycle after the one before it, and T4 comes one cycle after the first high ready sample. The bench drives inputs and samples outputs on falling edges and walks a cycle-by-cycle model of each transfer. It checks every state as it occurs, placing ready and the read data just before the rising edge that should sample them. Between reads and writes, zero to three wait states, both byte-lane settings, and chained versus idle-separated requests, the sweep reaches every state transition.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_hi,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          bhe_n,
  output logic          den,
  output logic          dt_r,
  input  logic          ready_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [2:0]    bus_state
);
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2,
                         S_T3 = 3'd3, S_TW = 3'd4, S_T4 = 3'd5;

  logic [2:0]    st, st_nx;
  logic [AW-1:0] a_q;
  logic          w_q, hi_q;
  logic [DW-1:0] wd_q, rd_q;

  wire take    = req_valid & req_ready;
  wire smp     = (st == S_T3) | (st == S_TW);
  wire data_ph = (st == S_T2) | smp | (st == S_T4);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:      st_nx = take ? S_T1 : S_IDLE;
      S_T1:        st_nx = S_T2;
      S_T2:        st_nx = S_T3;
      S_T3, S_TW:  st_nx = ready_in ? S_T4 : S_TW;
      S_T4:        st_nx = take ? S_T1 : S_IDLE;
      default:     st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      a_q  <= '0;
      w_q  <= 1'b0;
      hi_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        a_q  <= req_addr;
        w_q  <= req_write;
        hi_q <= req_hi;
        wd_q <= req_wdata;
      end
      if (smp && ready_in && !w_q) rd_q <= ad_in;
    end
  end

  assign req_ready = (st == S_IDLE) | (st == S_T4);
  assign ale       = (st == S_T1);
  assign den       = data_ph;
  assign dt_r      = (st != S_IDLE) & w_q;
  assign ad_oe     = (st == S_T1) | (data_ph & w_q);
  assign ad_out    = (st == S_T1) ? a_q : (data_ph & w_q) ? AW'(wd_q) : '0;
  assign bhe_n     = ~((st == S_T1) & hi_q);
  assign rsp_valid = (st == S_T4);
  assign rsp_rdata = rd_q;
  assign bus_state = st;
endmodule

module mux_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_state,
  input logic       ale,
  input logic       den,
  input logic       dt_r,
  input logic       ad_oe,
  input logic       ready_in,
  input logic       rsp_valid,
  input logic       req_valid,
  input logic       req_ready
);
  // R3
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && bus_state == 3'd2));
  // R7
  den_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !den);
  // R4
  wait_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_state == 3'd3 || bus_state == 3'd4) && !ready_in) |=> bus_state == 3'd4);
  // R4
  ready_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_state == 3'd3 || bus_state == 3'd4) && ready_in) |=> bus_state == 3'd5);
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (den && !dt_r) |-> !ad_oe);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_valid && req_ready) |=> ale);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (.*);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_hi = 0, ready_in = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic req_ready, ad_oe, ale, bhe_n, den, dt_r, rsp_valid;
  logic [19:0] ad_out;
  logic [15:0] rsp_rdata;
  logic [2:0] bus_state;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(bus_state == 0, {tag, " state"}, bus_state, 0);
    chk(!ale && !den && !ad_oe && !dt_r && bhe_n && ad_out == 0,
        {tag, " idle outputs"}, {ale, den, ad_oe, dt_r, bhe_n}, 5'b00001);
    chk(req_ready && !rsp_valid, {tag, " ready/rsp"}, {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic run(input bit wr, input logic [19:0] a, input bit hi,
                     input logic [15:0] wd, input logic [15:0] rd, input int nw);
    req_valid = 1; req_write = wr; req_addr = a; req_hi = hi; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    ad_in = ~rd;
    chk(bus_state == 1 && ale && ad_oe && !den, "R2 T1 state/strobes", bus_state, 1);
    chk(ad_out == a, "R2 T1 address", ad_out, a);
    chk(bhe_n == !hi && dt_r == wr, "R2 T1 bhe/dir", {bhe_n, dt_r}, {!hi, wr});
    chk(!req_ready, "R9 busy in T1", req_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(bus_state == 2 && !ale, "R3 T2", bus_state, 2);
    chk(den, "R7 den in T2", den, 1);
    if (wr) chk(ad_oe && ad_out == {4'h0, wd} && dt_r, "R5 T2 write drive", ad_out, {4'h0, wd});
    else    chk(!ad_oe && ad_out == 0 && !dt_r, "R6 T2 read release", ad_oe, 0);
    for (int c = 0; c <= nw; c++) begin
      @(posedge clk); @(negedge clk);
      chk(bus_state == ((c == 0) ? 3 : 4), "R4 T3/wait state", bus_state, (c == 0) ? 3 : 4);
      chk(den && ad_oe == wr && dt_r == wr, "R7 data phase enables", {den, ad_oe, dt_r}, {1'b1, wr, wr});
      ready_in = (c == nw);
      ad_in = (c == nw) ? rd : (rd ^ 16'(c + 1) ^ 16'h5a00);
    end
    @(posedge clk); @(negedge clk);
    ready_in = 0; ad_in = ~rd;
    chk(bus_state == 5, "R4 T4 after ready", bus_state, 5);
    chk(rsp_valid && req_ready && den, "R8 completion in T4", {rsp_valid, req_ready, den}, 3'b111);
    if (wr) chk(ad_out == {4'h0, wd} && ad_oe && dt_r, "R5 T4 write drive", ad_out, {4'h0, wd});
    else    chk(rsp_rdata == rd && !ad_oe, "R6 read capture", rsp_rdata, rd);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_chk("R1 reset");
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 after release");
    for (int wr = 0; wr < 2; wr++)
      for (int nw = 0; nw < 4; nw++)
        for (int hi = 0; hi < 2; hi++) begin
          int k = wr * 8 + nw * 2 + hi;
          logic [19:0] a = 20'((k * 40503 + 13) & 20'hFFFFF);
          logic [15:0] wd = 16'(k * 4099 + 7);
          logic [15:0] rd = 16'(k * 2311 + 16'hA5);
          run(wr[0], a, hi[0], wd, rd, nw);
          if (k % 3 == 2) begin
            @(posedge clk); @(negedge clk);
            idle_chk("R9 back to idle");
            repeat (2) begin
              ready_in = 1; ad_in = 16'hFFFF;
              @(posedge clk); @(negedge clk);
              idle_chk("R10 idle holds");
              ready_in = 0;
            end
          end
        end
    run(1'b0, 20'h12345, 1'b1, 16'h0, 16'hBEEF, 2);
    @(posedge clk); @(negedge clk);
    idle_chk("R9 final idle");
    chk(rsp_rdata == 16'hBEEF, "R6 rdata held", rsp_rdata, 16'hBEEF);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule